// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Incrementing Pointer

This block is a serial two-wire bus target that gives an external host access to a small bank of eight-bit registers. It runs on a fast system clock and oversamples the clock line and the data line through synchronisers. It never drives either line high: it only pulls the data line low through an open-drain enable.

A transfer carries a seven-bit device address, a direction bit and an eight-bit sub-address, which loads an internal pointer. Data bytes follow. On a write, each byte goes to the register the pointer selects. A repeated start with the read bit set then streams bytes out from the pointer. The pointer steps forward after every data byte, so a single transfer can reach a run of consecutive registers.

Top module: `i2c_regfile_target`

## Requirements
- R1: A falling data line while the clock line is high (start, including a repeated start) restarts address reception from any state. A rising data line while the clock line is high (stop) returns the block to idle with the data line released. A stop in the middle of a byte writes nothing.
- R2: The address byte is seven address bits sent MSB first, then a direction bit (1 = read, 0 = write). The block pulls the data line low during the ninth clock only when the seven bits equal `DEV_ADDR`.
- R3: After an address mismatch the block keeps the data line released for the whole transfer and changes no register until the next start.
- R4: In a write transfer, the byte after the address is acknowledged and loads the register pointer. The pointer keeps its value across stop and repeated start.
- R5: Each write data byte is acknowledged, stored at the pointer, and the pointer then advances by one.
- R6: The pointer advances from entry `REG_COUNT-1` (31) to entry 0.
- R7: Pointer values from `REG_COUNT` to 255 are unimplemented. Writes there are acknowledged and discarded, and reads there return 0x00. From such a value the pointer steps by one modulo 256, so 0xFF is followed by 0x00.
- R8: After a matching address with the read bit set, the block sends the register at the pointer, MSB first.
- R9: When the host acknowledges a read byte, the pointer advances and the next byte follows. When the host does not acknowledge, the data line is released and the pointer keeps its value.
- R10: The data-line enable changes only after a falling clock edge, or after a start or stop.
- R11: After reset all registers and the pointer are zero and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest situation to reach from the pins is the pointer running past an edge of the storage. That includes crossing from the last entry back to zero, and stepping from 0xFF back into implemented space after a run of writes that were discarded. It also includes a read that the host cuts short with a NACK, where the pointer must not advance. The stimulus reaches these cases with directed sub-addresses placed just below those edges, followed by bursts long enough to cross them. It then reads the results back through a read at the current pointer with no sub-address phase. Randomised bursts at start points spread across implemented and unimplemented addresses are checked against a bench model of the storage and the pointer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_END, ST_ACK_A,
    ST_SUB, ST_SUB_END, ST_ACK_S,
    ST_WR, ST_WR_END, ST_ACK_W,
    ST_RD, ST_RACK, ST_RACK_END
  } tgt_state_e;

  // next pointer: the last implemented entry folds to zero, all else counts modulo 256
  function automatic logic [7:0] ptr_step(input logic [7:0] p, input int unsigned last);
    return (p == 8'(last)) ? 8'd0 : p + 8'd1;
  endfunction

  // seven upper bits of the received frame against the own address
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] raddr,
  output logic [7:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] LIMIT = 9'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic w_in, r_in;

  assign w_in = {1'b0, waddr} < LIMIT;
  assign r_in = {1'b0, raddr} < LIMIT;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[g] <= '0;
        else if (we && w_in && (waddr[IDX_W-1:0] == IDX_W'(g))) mem[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = r_in ? mem[raddr[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         REG_COUNT   = 32,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int unsigned LAST = REG_COUNT - 1;

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_evt, stop_evt, byte_hit, wr_en;
  logic [7:0] shreg, ptr, rd_data;
  logic [2:0] cnt;
  logic       rw;
  tgt_state_e state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in),
    .level(scl_s), .rise(scl_rise), .fall(scl_fall));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_in(sda_in),
    .level(sda_s), .rise(sda_rise), .fall(sda_fall));

  // named bus events
  assign start_evt = scl_s & sda_fall;
  assign stop_evt  = scl_s & sda_rise;
  assign byte_hit  = addr_hit(shreg, DEV_ADDR);
  assign wr_en     = (state == ST_WR_END) & scl_fall;

  i2c_regbank #(.DEPTH(REG_COUNT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WR: if (scl_rise) begin
          shreg <= {shreg[6:0], sda_s};
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            case (state)
              ST_ADDR: state <= ST_ADDR_END;
              ST_SUB:  state <= ST_SUB_END;
              default: state <= ST_WR_END;
            endcase
          end
        end
        ST_ADDR_END: if (scl_fall) begin
          if (byte_hit) begin
            sda_oe <= 1'b1;
            rw     <= shreg[0];
            state  <= ST_ACK_A;
          end else begin
            state  <= ST_IDLE;
          end
        end
        ST_ACK_A: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
            state  <= ST_RD;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_SUB;
          end
        end
        ST_SUB_END: if (scl_fall) begin
          ptr    <= shreg;
          sda_oe <= 1'b1;
          state  <= ST_ACK_S;
        end
        ST_ACK_S, ST_ACK_W: if (scl_fall) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          state  <= ST_WR;
        end
        ST_WR_END: if (scl_fall) begin
          ptr    <= ptr_step(ptr, LAST);
          sda_oe <= 1'b1;
          state  <= ST_ACK_W;
        end
        ST_RD: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
            cnt    <= cnt + 3'd1;
          end
        end
        ST_RACK: if (scl_rise) begin
          if (!sda_s) begin
            ptr   <= ptr_step(ptr, LAST);
            state <= ST_RACK_END;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_RACK_END: if (scl_fall) begin
          cnt    <= '0;
          shreg  <= rd_data;
          sda_oe <= ~rd_data[7];
          state  <= ST_RD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
#(
  parameter int REG_COUNT = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_s,
  input logic       sda_oe,
  input logic       wr_en,
  input logic       byte_hit,
  input logic [7:0] ptr,
  input tgt_state_e state
);
  localparam int unsigned LAST = REG_COUNT - 1;

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_oe);

  assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR));

  assert_miss_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_END && scl_fall && !byte_hit && !start_evt && !stop_evt)
      |=> !sda_oe && (state == ST_IDLE));

  assert_hit_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_END && scl_fall && byte_hit && !start_evt && !stop_evt)
      |=> sda_oe);

  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start_evt && !stop_evt) |=> sda_oe);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start_evt && !stop_evt) |=> ptr == ptr_step($past(ptr), LAST));

  assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && scl_rise && sda_s && !start_evt && !stop_evt)
      |=> !sda_oe && (state == ST_IDLE) && $stable(ptr));

  assert_oe_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_oe_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));
endmodule

bind i2c_regfile_target i2c_tgt_checker #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s), .sda_oe(sda_oe),
  .wr_en(wr_en), .byte_hit(byte_hit), .ptr(ptr), .state(state));

// File: tb/sim_i2c_regfile_target.sv
`timescale 1ns/1ps
module sim_i2c_regfile_target;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int NREG = 32;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = host_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_regfile_target #(.DEV_ADDR(DEV), .REG_COUNT(NREG), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe));

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] ref_mem [NREG];
  int ref_ptr = 0;
  logic [7:0] wbuf [8];

  function automatic int ref_next(input int p);
    if (p == NREG - 1) return 0;
    return (p + 1) % 256;
  endfunction

  function automatic logic [7:0] ref_read(input int p);
    return (p < NREG) ? ref_mem[p] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_cycle(input bit drive, output bit seen);
    host_sda = drive; tick(Q);
    scl = 1'b1;       tick(Q);
    seen = sda_line;  tick(Q);
    scl = 1'b0;       tick(Q);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    scl = 1'b1;      tick(Q);
    host_sda = 1'b0; tick(Q);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    scl = 1'b1;      tick(Q);
    host_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, s);
      d = {d[6:0], s};
    end
    bit_cycle(!give_ack, s);
  endtask

  // write transfer: address, sub-address, n data bytes from wbuf
  task automatic do_write(input logic [6:0] dev, input logic [7:0] sub, input int n, input string req);
    bit ack;
    bit hit = (dev == DEV);
    bus_start();
    send_byte({dev, 1'b0}, ack);
    chk(ack == hit, "R2 address ack", ack, hit);
    send_byte(sub, ack);
    chk(ack == hit, "R4 sub-address ack", ack, hit);
    if (hit) ref_ptr = sub;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack == hit, req, ack, hit);
      if (hit) begin
        if (ref_ptr < NREG) ref_mem[ref_ptr] = wbuf[i];
        ref_ptr = ref_next(ref_ptr);
      end
    end
    bus_stop();
  endtask

  // read n bytes at the current pointer, optional sub-address + repeated start first
  task automatic do_read(input bit set_sub, input logic [7:0] sub, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (set_sub) begin
      send_byte({DEV, 1'b0}, ack);
      chk(ack, "R2 address ack", ack, 1);
      send_byte(sub, ack);
      chk(ack, "R4 sub-address ack", ack, 1);
      ref_ptr = sub;
      bus_start();
    end
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R8 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == ref_read(ref_ptr), req, d, ref_read(ref_ptr));
      if (i != n - 1) ref_ptr = ref_next(ref_ptr);
    end
    chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) ref_mem[i] = 8'h00;
    tick(5);
    chk(sda_oe == 1'b0, "R11 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);
    // R11: pointer zero and storage cleared, read with no sub-address phase
    do_read(1'b0, 8'h00, 2, "R11 reset contents");

    // R4 R5: plain burst write then read back
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(DEV, 8'h04, 3, "R5 data ack");
    do_read(1'b1, 8'h04, 3, "R8 readback");

    // R3: wrong address, nothing acked or stored
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    do_write(DEV ^ 7'h01, 8'h04, 2, "R3 mismatch data no ack");
    do_read(1'b1, 8'h04, 2, "R3 contents unchanged");

    // R6: burst across the last entry
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h30 + 8'(i);
    do_write(DEV, 8'h1E, 4, "R6 wrap write ack");
    do_read(1'b1, 8'h1E, 4, "R6 wrap readback");

    // R7: unimplemented range, 0xFF steps to 0x00
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
    do_write(DEV, 8'hFE, 3, "R7 unimplemented ack");
    do_read(1'b1, 8'hFE, 3, "R7 unimplemented readback");
    do_read(1'b1, 8'h40, 1, "R7 reads zero");

    // R9: NACK leaves pointer, next read continues from it
    do_read(1'b1, 8'h05, 2, "R9 first part");
    do_read(1'b0, 8'h00, 2, "R9 pointer after NACK");

    // R1: stop inside a data byte writes nothing, pointer kept from sub-address
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h06, ack);
    ref_ptr = 6;
    begin
      bit s;
      for (int i = 0; i < 3; i++) bit_cycle(1'b0, s);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    do_read(1'b0, 8'h00, 1, "R1 aborted byte not stored");

    // R1: start in the middle of a write restarts address reception
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h07, ack);
    ref_ptr = 7;
    wbuf[0] = 8'h77;
    do_write(DEV, 8'h08, 1, "R1 restart write ack");
    do_read(1'b1, 8'h07, 2, "R1 restart contents");

    // random mix
    for (int t = 0; t < 14; t++) begin
      int n = 1 + int'($urandom % 4);
      logic [7:0] sub = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % NREG);
      if ($urandom % 2) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(DEV, sub, n, "R5 random write");
      end else begin
        do_read(1'b1, sub, n, "R8 random read");
      end
    end
    for (int p = 0; p < NREG; p += 4) do_read(1'b1, 8'(p), 4, "R5 final sweep");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule